// File: doc/BRIEF.md
# Virtual-Channel Router Allocator

This block is the control plane of a small input-buffered crossbar router whose input buffers are divided into virtual channels. It sees the head of every input virtual channel (request, head and tail flags, the output port chosen by an external route stage and a wraparound flag), and it decides which flits cross the crossbar in each cycle. The flit storage and the route computation are outside the block.

Each input virtual channel has its own small state machine: idle, waiting for an output channel, and active. Allocation runs in two stages. First, a packet claims a free virtual channel on the downstream input of its chosen output, and it holds that channel until its tail flit leaves. Then, in every cycle, a separable switch allocator picks one active channel per input port and one input port per output port, using round-robin at both levels. A flit is eligible only while the counter for its downstream channel shows a free slot. Virtual channels are split into a lower and an upper class. A hop over a wraparound link moves a packet into the upper class, which breaks the dependency cycles of a torus ring.

All outputs are registered. A grant seen in a cycle refers to the flit that was presented at the inputs in the cycle before it, so the upstream buffer pops that flit and presents the next one before the following edge.

Top module: `vc_switch_alloc`

## Requirements
- R1: While reset is high, and in the first cycle after it, grant_o and xbar_vld_o are all zero. After reset every downstream channel counter holds DEPTH and every downstream channel is free, so DEPTH flits can go to one channel with no credit returned.
- R2: A packet's head flit on an idle input channel leads to the claim of one free downstream channel on its output. All flits of that packet use the same downstream channel, and no other packet is given that channel until the packet's tail flit has been granted.
- R3: Downstream channel numbers c < V/2 form class 0 and c >= V/2 form class 1. A packet gets a class-1 channel if its wraparound flag is set or if its input channel index is V/2 or more. Otherwise it gets a class-0 channel.
- R4: grant_o[i], with i = port*V + vc, goes high only in the cycle after an edge at which in_req[i] was high. It refers to the flit presented in the cycle before.
- R5: Each downstream channel counter decrements when a flit is granted to it and increments on credit_ret[out*V + c]. No flit is granted while the count is zero, and the counter never exceeds DEPTH. A flit that cannot go waits and is not lost.
- R6: Each output grants at most one input port per cycle. xbar_vld_o[o] is high exactly when a flit is granted to output o. xbar_sel_o[o*PW +: PW] then holds the input port number, and out_vc_o[o*VW +: VW] holds the downstream channel. The output is always the packet's route port.
- R7: At most one virtual channel of an input port is granted in a cycle.
- R8: When two input ports keep sending to one output, the output alternates between them cycle by cycle.
- R9: A channel stalled for lack of credits does not block another channel of the same input port that targets a different output.
- R10: Every flit of every packet is granted exactly once, in order, and every packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | P*V | A flit is present at the head of input channel i |
| in_head | input | P*V | The presented flit is a head flit |
| in_tail | input | P*V | The presented flit is a tail flit |
| in_port | input | P*V*PW | Output port for the packet, valid with the head flit |
| in_wrap | input | P*V | The hop crosses a wraparound link, valid with the head flit |
| credit_ret | input | P*V | One slot freed at downstream channel c of output o (bit o*V+c) |
| grant_o | output | P*V | The flit presented on channel i in the previous cycle crosses now |
| xbar_vld_o | output | P | Output o carries a flit this cycle |
| xbar_sel_o | output | P*PW | Input port that drives output o |
| out_vc_o | output | P*VW | Downstream channel of the flit on output o |

## Verification
Two ports streaming long packets into one output show whether the output arbiter alternates, or whether it favours one port. A packet to an output whose credits are held back, together with a second packet on another channel of the same port, separates true per-channel flow control from a single shared queue. The same test shows that exactly DEPTH flits go out before the stall. Three lower-class packets aimed at one output, where only two lower-class channels exist, test the reuse of a channel after a tail. Wraparound packets test the class switch. A long random phase with gaps in requests and sparse credit returns then checks ownership, credits, crossbar consistency and completion under contention.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_ROUTE  = 2'd1,
    VC_ACTIVE = 2'd2
  } vc_state_e;
endpackage

// File: rtl/vsa_rr_arb.sv
// Round-robin arbiter: the search starts at ptr_q, and the pointer moves
// past the winner only when adv_i confirms the grant was used.
module vsa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  int            win;
  int            cand;

  always_comb begin
    win  = 0;
    cand = 0;
    gnt_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = int'(ptr_q) + k;
      if (cand >= N) cand = cand - N;
      if (req_i[cand]) win = cand;
    end
    if (|req_i) gnt_o[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (adv_i && |req_i) begin
      ptr_q <= (win == N - 1) ? '0 : IW'(win + 1);
    end
  end
endmodule

// File: rtl/vsa_credit_bank.sv
// Free-slot counters for the downstream channels behind one output.
module vsa_credit_bank #(
  parameter int V     = 4,
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [V-1:0]                      take_i,
  input  logic [V-1:0]                      give_i,
  output logic [V-1:0]                      avail_o,
  output logic [V*$clog2(DEPTH+1)-1:0]      cnt_o
);
  localparam int CW = $clog2(DEPTH + 1);

  for (genvar c = 0; c < V; c++) begin : g_cnt
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= CW'(DEPTH);
      end else if (take_i[c] && !give_i[c]) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!take_i[c] && give_i[c]) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
    assign avail_o[c]          = (cnt_q != '0);
    assign cnt_o[c*CW +: CW]   = cnt_q;
  end
endmodule

// File: rtl/vsa_in_vc.sv
// Control state for one input virtual channel.
module vsa_in_vc
  import vsa_pkg::*;
#(
  parameter int PW    = 2,
  parameter int VW    = 2,
  parameter bit UPPER = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic          head_i,
  input  logic          tail_i,
  input  logic [PW-1:0] port_i,
  input  logic          wrap_i,
  input  logic          va_win_i,
  input  logic [VW-1:0] va_vc_i,
  input  logic          sa_win_i,
  output vc_state_e     state_o,
  output logic [PW-1:0] port_o,
  output logic          cls_o,
  output logic [VW-1:0] ovc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= VC_IDLE;
      port_o  <= '0;
      cls_o   <= 1'b0;
      ovc_o   <= '0;
    end else begin
      unique case (state_o)
        VC_IDLE: begin
          if (req_i && head_i) begin
            port_o  <= port_i;
            cls_o   <= wrap_i | UPPER;
            state_o <= VC_ROUTE;
          end
        end
        VC_ROUTE: begin
          if (va_win_i) begin
            ovc_o   <= va_vc_i;
            state_o <= VC_ACTIVE;
          end
        end
        VC_ACTIVE: begin
          if (sa_win_i && tail_i) state_o <= VC_IDLE;
        end
        default: state_o <= VC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vc_switch_alloc.sv
module vc_switch_alloc
  import vsa_pkg::*;
#(
  parameter int P     = 4,
  parameter int V     = 4,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [P*V-1:0]            in_req,
  input  logic [P*V-1:0]            in_head,
  input  logic [P*V-1:0]            in_tail,
  input  logic [P*V*$clog2(P)-1:0]  in_port,
  input  logic [P*V-1:0]            in_wrap,
  input  logic [P*V-1:0]            credit_ret,
  output logic [P*V-1:0]            grant_o,
  output logic [P-1:0]              xbar_vld_o,
  output logic [P*$clog2(P)-1:0]    xbar_sel_o,
  output logic [P*$clog2(V)-1:0]    out_vc_o
);
  localparam int NIV  = P * V;
  localparam int PW   = $clog2(P);
  localparam int VW   = $clog2(V);
  localparam int HALF = V / 2;
  localparam int CW   = $clog2(DEPTH + 1);

  // per input channel state
  vc_state_e     st    [NIV];
  logic [PW-1:0] rport [NIV];
  logic          rcls  [NIV];
  logic [VW-1:0] rovc  [NIV];
  logic [NIV-1:0] va_win;
  logic [NIV-1:0] sa_win;
  logic [VW-1:0] va_vc [NIV];

  for (genvar i = 0; i < NIV; i++) begin : g_in
    vsa_in_vc #(
      .PW    (PW),
      .VW    (VW),
      .UPPER ((i % V) >= HALF)
    ) u_vc (
      .clk      (clk),
      .rst      (rst),
      .req_i    (in_req[i]),
      .head_i   (in_head[i]),
      .tail_i   (in_tail[i]),
      .port_i   (in_port[i*PW +: PW]),
      .wrap_i   (in_wrap[i]),
      .va_win_i (va_win[i]),
      .va_vc_i  (va_vc[i]),
      .sa_win_i (sa_win[i]),
      .state_o  (st[i]),
      .port_o   (rport[i]),
      .cls_o    (rcls[i]),
      .ovc_o    (rovc[i])
    );
  end

  // ---------------- downstream channel ownership ----------------
  logic [V-1:0]  busy_q   [P];
  logic [V-1:0]  busy_d   [P];
  logic [1:0]    cls_free [P];
  logic [VW-1:0] cls_pick [P][2];

  always_comb begin
    for (int o = 0; o < P; o++) begin
      for (int c = 0; c < 2; c++) begin
        cls_free[o][c] = 1'b0;
        cls_pick[o][c] = '0;
        for (int k = HALF - 1; k >= 0; k--) begin
          if (!busy_q[o][c*HALF + k]) begin
            cls_free[o][c] = 1'b1;
            cls_pick[o][c] = VW'(c*HALF + k);
          end
        end
      end
    end
  end

  // ---------------- stage 1: output channel claim ----------------
  logic [NIV-1:0] va_req [P];
  logic [NIV-1:0] va_gnt [P];

  always_comb begin
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < NIV; i++) begin
        va_req[o][i] = (st[i] == VC_ROUTE) && (rport[i] == PW'(o)) &&
                       cls_free[o][rcls[i]];
      end
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_va
    vsa_rr_arb #(.N(NIV)) u_va_arb (
      .clk   (clk),
      .rst   (rst),
      .req_i (va_req[o]),
      .adv_i (1'b1),
      .gnt_o (va_gnt[o])
    );
  end

  always_comb begin
    for (int i = 0; i < NIV; i++) begin
      va_win[i] = va_gnt[rport[i]][i];
      va_vc[i]  = cls_pick[rport[i]][rcls[i]];
    end
  end

  always_comb begin
    for (int o = 0; o < P; o++) busy_d[o] = busy_q[o];
    for (int o = 0; o < P; o++) begin
      for (int i = 0; i < NIV; i++) begin
        if (va_gnt[o][i]) busy_d[o][cls_pick[o][rcls[i]]] = 1'b1;
      end
    end
    for (int i = 0; i < NIV; i++) begin
      if (sa_win[i] && in_tail[i]) busy_d[rport[i]][rovc[i]] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < P; o++) begin
      if (rst) busy_q[o] <= '0;
      else     busy_q[o] <= busy_d[o];
    end
  end

  // ---------------- credits ----------------
  logic [V-1:0]      cred_ok   [P];
  logic [V-1:0]      cred_take [P];
  logic [P*V*CW-1:0] cred_flat;

  always_comb begin
    for (int o = 0; o < P; o++) begin
      cred_take[o] = '0;
      for (int i = 0; i < NIV; i++) begin
        if (sa_win[i] && rport[i] == PW'(o)) cred_take[o][rovc[i]] = 1'b1;
      end
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_cred
    vsa_credit_bank #(.V(V), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .take_i  (cred_take[o]),
      .give_i  (credit_ret[o*V +: V]),
      .avail_o (cred_ok[o]),
      .cnt_o   (cred_flat[o*V*CW +: V*CW])
    );
  end

  // ---------------- stage 2: crossbar allocation ----------------
  logic [V-1:0]  s1_req [P];
  logic [V-1:0]  s1_gnt [P];
  logic [P-1:0]  s1_any;
  logic [P-1:0]  s1_adv;
  logic [PW-1:0] s1_tgt [P];
  logic [VW-1:0] s1_vc  [P];
  logic [P-1:0]  s2_req [P];
  logic [P-1:0]  s2_gnt [P];

  always_comb begin
    for (int p = 0; p < P; p++) begin
      for (int v = 0; v < V; v++) begin
        s1_req[p][v] = (st[p*V+v] == VC_ACTIVE) && in_req[p*V+v] &&
                       cred_ok[rport[p*V+v]][rovc[p*V+v]];
      end
    end
  end

  for (genvar p = 0; p < P; p++) begin : g_s1
    vsa_rr_arb #(.N(V)) u_in_arb (
      .clk   (clk),
      .rst   (rst),
      .req_i (s1_req[p]),
      .adv_i (s1_adv[p]),
      .gnt_o (s1_gnt[p])
    );
  end

  always_comb begin
    for (int p = 0; p < P; p++) begin
      s1_any[p] = |s1_req[p];
      s1_tgt[p] = '0;
      s1_vc[p]  = '0;
      for (int v = 0; v < V; v++) begin
        if (s1_gnt[p][v]) begin
          s1_tgt[p] = rport[p*V+v];
          s1_vc[p]  = rovc[p*V+v];
        end
      end
    end
    for (int o = 0; o < P; o++) begin
      for (int p = 0; p < P; p++) begin
        s2_req[o][p] = s1_any[p] && (s1_tgt[p] == PW'(o));
      end
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_s2
    vsa_rr_arb #(.N(P)) u_out_arb (
      .clk   (clk),
      .rst   (rst),
      .req_i (s2_req[o]),
      .adv_i (1'b1),
      .gnt_o (s2_gnt[o])
    );
  end

  logic [PW-1:0] win_port [P];
  logic [VW-1:0] win_vc   [P];

  always_comb begin
    for (int p = 0; p < P; p++) begin
      s1_adv[p] = 1'b0;
      for (int o = 0; o < P; o++) s1_adv[p] = s1_adv[p] | s2_gnt[o][p];
      for (int v = 0; v < V; v++) sa_win[p*V+v] = s1_gnt[p][v] & s1_adv[p];
    end
    for (int o = 0; o < P; o++) begin
      win_port[o] = '0;
      win_vc[o]   = '0;
      for (int p = 0; p < P; p++) begin
        if (s2_gnt[o][p]) begin
          win_port[o] = PW'(p);
          win_vc[o]   = s1_vc[p];
        end
      end
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o    <= '0;
      xbar_vld_o <= '0;
      xbar_sel_o <= '0;
      out_vc_o   <= '0;
    end else begin
      grant_o <= sa_win;
      for (int o = 0; o < P; o++) begin
        xbar_vld_o[o]          <= |s2_req[o];
        xbar_sel_o[o*PW +: PW] <= win_port[o];
        out_vc_o[o*VW +: VW]   <= win_vc[o];
      end
    end
  end
endmodule

// File: rtl/vsa_checker.sv
module vsa_checker #(
  parameter int P     = 4,
  parameter int V     = 4,
  parameter int DEPTH = 4
) (
  input logic                               clk,
  input logic                               rst,
  input logic [P*V-1:0]                     in_req,
  input logic [P*V-1:0]                     grant_o,
  input logic [P-1:0]                       xbar_vld_o,
  input logic [P*V*$clog2(DEPTH+1)-1:0]     cred_flat
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (grant_o == '0 && xbar_vld_o == '0))
    else $error("R1 outputs not quiet after reset");

  assert_xbar_count_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(grant_o) == $countones(xbar_vld_o))
    else $error("R6 grants and crossbar selects disagree");

  for (genvar i = 0; i < P*V; i++) begin : g_req
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
      grant_o[i] |-> $past(in_req[i]))
      else $error("R4 grant without request");
  end

  for (genvar p = 0; p < P; p++) begin : g_port
    assert_one_vc_per_port_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(grant_o[p*V +: V]) <= 1)
      else $error("R7 two channels of one port granted");
  end

  for (genvar k = 0; k < P*V; k++) begin : g_cred
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      cred_flat[k*CW +: CW] <= CW'(DEPTH))
      else $error("R5 credit counter above depth");
  end
endmodule

bind vc_switch_alloc vsa_checker #(.P(P), .V(V), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_req     (in_req),
  .grant_o    (grant_o),
  .xbar_vld_o (xbar_vld_o),
  .cred_flat  (cred_flat)
);

// File: tb/vc_switch_alloc_tb.sv
module vc_switch_alloc_tb_top;
  localparam int P = 4;
  localparam int V = 4;
  localparam int DEPTH = 4;
  localparam int NIV = P * V;
  localparam int PW = $clog2(P);
  localparam int VW = $clog2(V);
  localparam int HALF = V / 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NIV-1:0]    in_req = '0, in_head = '0, in_tail = '0, in_wrap = '0, credit_ret = '0;
  logic [NIV*PW-1:0] in_port = '0;
  logic [NIV-1:0]    grant_o;
  logic [P-1:0]      xbar_vld_o;
  logic [P*PW-1:0]   xbar_sel_o;
  logic [P*VW-1:0]   out_vc_o;

  vc_switch_alloc #(.P(P), .V(V), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_req(in_req), .in_head(in_head), .in_tail(in_tail),
    .in_port(in_port), .in_wrap(in_wrap), .credit_ret(credit_ret),
    .grant_o(grant_o), .xbar_vld_o(xbar_vld_o), .xbar_sel_o(xbar_sel_o),
    .out_vc_o(out_vc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, delivered = 0;
  bit finished = 0;
  bit have_pkt [NIV];
  bit drv_req [NIV];
  int plen [NIV], pidx [NIV], pdst [NIV], pwrap [NIV], pvc [NIV], left [NIV];
  int owner [P][V], credits [P][V], outst [P][V];
  bit ret_drv [P][V];
  bit ret_en [P];
  int req_pct = 100, ret_pct = 100;
  bit auto_gen = 0, log_on = 0;
  int log0 [64];
  int logn = 0;

  function automatic int exp_cls(int i, int w);
    return (w != 0 || (i % V) >= HALF) ? 1 : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic load(int i, int dst, int len, int w);
    have_pkt[i] = 1; pdst[i] = dst; plen[i] = len; pwrap[i] = w; pidx[i] = 0;
  endtask

  task automatic step();
    int ocnt [P];
    int pcnt [P];
    for (int i = 0; i < NIV; i++) begin
      if (auto_gen && !have_pkt[i] && left[i] > 0) begin
        load(i, int'($urandom_range(P-1)), 1 + int'($urandom_range(3)), int'($urandom_range(1)));
        left[i]--;
      end
      drv_req[i] = have_pkt[i] && ($urandom_range(99) < req_pct);
      in_req[i]  = drv_req[i];
      in_head[i] = have_pkt[i] && pidx[i] == 0;
      in_tail[i] = have_pkt[i] && pidx[i] == plen[i] - 1;
      in_port[i*PW +: PW] = have_pkt[i] ? PW'(pdst[i]) : '0;
      in_wrap[i] = have_pkt[i] && pwrap[i] != 0;
    end
    for (int o = 0; o < P; o++)
      for (int c = 0; c < V; c++) begin
        ret_drv[o][c] = outst[o][c] > 0 && ret_en[o] && ($urandom_range(99) < ret_pct);
        credit_ret[o*V+c] = ret_drv[o][c];
      end
    @(posedge clk); #1; cyc++;
    for (int o = 0; o < P; o++) begin ocnt[o] = 0; pcnt[o] = 0; end
    if (log_on && xbar_vld_o[0] && logn < 64) begin log0[logn] = int'(xbar_sel_o[0 +: PW]); logn++; end
    for (int i = 0; i < NIV; i++) begin
      if (grant_o[i]) begin
        int o, ovc, p;
        p = i / V;
        pcnt[p]++;
        chk(drv_req[i], "R4 grant without request", 0, 1);
        chk(have_pkt[i], "R10 grant with no flit pending", 0, 1);
        if (have_pkt[i]) begin
          o = pdst[i];
          ocnt[o]++;
          chk(xbar_vld_o[o] && int'(xbar_sel_o[o*PW +: PW]) == p, "R6 crossbar select",
              int'(xbar_sel_o[o*PW +: PW]), p);
          ovc = int'(out_vc_o[o*VW +: VW]);
          if (pidx[i] == 0) begin
            chk(owner[o][ovc] < 0, "R2 downstream channel already held", owner[o][ovc], -1);
            chk(((ovc >= HALF) ? 1 : 0) == exp_cls(i, pwrap[i]), "R3 channel class",
                ovc, exp_cls(i, pwrap[i]));
            owner[o][ovc] = i; pvc[i] = ovc;
          end else begin
            chk(ovc == pvc[i], "R2 channel changed inside packet", ovc, pvc[i]);
          end
          chk(credits[o][ovc] > 0, "R5 flit sent with no credit", credits[o][ovc], 1);
          credits[o][ovc]--; outst[o][ovc]++;
          pidx[i]++;
          if (pidx[i] == plen[i]) begin
            have_pkt[i] = 0; delivered++;
            if (owner[o][pvc[i]] == i) owner[o][pvc[i]] = -1;
          end
        end
      end
    end
    for (int o = 0; o < P; o++) begin
      chk(ocnt[o] == int'(xbar_vld_o[o]), "R6 output valid vs grants", int'(xbar_vld_o[o]), ocnt[o]);
      chk(pcnt[o] <= 1, "R7 one channel per input port", pcnt[o], 1);
    end
    for (int o = 0; o < P; o++)
      for (int c = 0; c < V; c++)
        if (ret_drv[o][c]) begin credits[o][c]++; outst[o][c]--; end
  endtask

  task automatic run_until_idle(int lim);
    int n = 0;
    bit busy = 1;
    while (busy && n < lim) begin
      step(); n++;
      busy = 0;
      for (int i = 0; i < NIV; i++) if (have_pkt[i] || left[i] > 0) busy = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int c0, c1, first_sw, base;
    void'($urandom(32'd7321));
    for (int i = 0; i < NIV; i++) begin have_pkt[i] = 0; left[i] = 0; pvc[i] = -1; end
    for (int o = 0; o < P; o++) begin
      ret_en[o] = 1;
      for (int c = 0; c < V; c++) begin owner[o][c] = -1; credits[o][c] = DEPTH; outst[o][c] = 0; end
    end
    repeat (3) @(posedge clk);
    #1;
    chk(grant_o == '0, "R1 grant during reset", int'(grant_o), 0);
    chk(xbar_vld_o == '0, "R1 crossbar valid during reset", int'(xbar_vld_o), 0);
    @(negedge clk); rst = 1'b0;
    step();
    chk(grant_o == '0 && xbar_vld_o == '0, "R1 quiet after reset", int'(grant_o), 0);

    // round-robin between two ports into output 0
    log_on = 1;
    load(0*V+0, 0, 8, 0);
    load(1*V+0, 0, 8, 0);
    run_until_idle(100);
    log_on = 0;
    chk(!have_pkt[0] && !have_pkt[V], "R10 both contenders finished", int'(have_pkt[0]), 0);
    c0 = 0; c1 = 0; first_sw = -1;
    for (int j = 0; j < logn; j++) begin
      if (j > 0 && first_sw >= 0 && c0 < 8 && c1 < 8)
        chk(log0[j] != log0[j-1], "R8 alternation at output 0", log0[j], 1 - log0[j-1]);
      if (first_sw < 0 && log0[j] != log0[0]) first_sw = j;
      if (log0[j] == 0) c0++; else c1++;
    end
    chk(first_sw == 1, "R8 second port served right after first", first_sw, 1);
    chk(c0 == 8 && c1 == 8, "R10 all flits through output 0", c0 + c1, 16);
    repeat (10) step();

    // blocked channel must not block its neighbour at the same port
    ret_en[1] = 0;
    load(0, 1, DEPTH + 3, 0);
    load(1, 2, 3, 0);
    begin
      int n = 0;
      while (have_pkt[1] && n < 60) begin step(); n++; end
    end
    chk(!have_pkt[1], "R9 neighbour channel completed", int'(have_pkt[1]), 0);
    chk(have_pkt[0], "R9 stalled packet still pending", int'(have_pkt[0]), 1);
    repeat (20) step();
    chk(pidx[0] == DEPTH, "R5 exactly DEPTH flits before stall (R1 initial credits)", pidx[0], DEPTH);
    ret_en[1] = 1;
    run_until_idle(100);
    chk(!have_pkt[0], "R10 stalled packet resumed and finished", int'(have_pkt[0]), 0);
    repeat (10) step();

    // wraparound class switch
    load(2*V+0, 3, 2, 1);
    load(2*V+2, 3, 2, 0);
    load(3*V+1, 3, 2, 0);
    run_until_idle(100);
    chk(pvc[2*V+0] >= HALF, "R3 wrap hop takes upper class", pvc[2*V+0], HALF);
    chk(pvc[2*V+2] >= HALF, "R3 upper input stays upper", pvc[2*V+2], HALF);
    chk(pvc[3*V+1] < HALF, "R3 plain hop stays lower", pvc[3*V+1], 0);
    repeat (10) step();

    // more lower-class packets than lower-class channels on one output
    load(0*V+0, 1, 3, 0);
    load(1*V+0, 1, 3, 0);
    load(2*V+0, 1, 3, 0);
    run_until_idle(100);
    chk(!have_pkt[0] && !have_pkt[V] && !have_pkt[2*V], "R2 channel reuse after tail",
        int'(have_pkt[2*V]), 0);
    repeat (10) step();

    // random traffic
    base = delivered;
    req_pct = 80; ret_pct = 40; auto_gen = 1;
    for (int i = 0; i < NIV; i++) left[i] = 6;
    run_until_idle(30000);
    chk(delivered - base == NIV * 6, "R10 random traffic all delivered", delivered - base, NIV * 6);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule